// File: doc/BRIEF.md
# SDRAM Byte Mask Latency Path

This block sits on the device-side data path of a synchronous DRAM and turns the per-byte mask inputs into two kinds of lane control. On the read side, each mask bit becomes an output enable for its byte lane two clock cycles after the bit is sampled. On the write side, the mask bit blocks the array write strobe for its lane in the cycle the bit is sampled. The two paths have different latencies, so a mask raised partway through a write burst stops the masked beat at once. Raising a mask two cycles ahead of read data blanks the output on the beat it is aimed at.

The clock enable freezes the block's internal time base. While it is low, the read mask pipeline keeps its contents, a mask sampled in that cycle is dropped, and no array write is issued. Burst addressing and the storage array are outside this block. It only gates the lane controls and the write data that go to the array.

Top module: `sdram_dqm_path`

## Requirements
- R1: The synchronous active-high reset clears the read mask pipeline, so in the first two cycles after reset every lane's read output enable follows the read-valid input.
- R2: A mask bit sampled high at a rising edge where clock enable is high, followed by a second edge where clock enable is high, drives that lane's read output enable low in the cycle after that second edge. That is two cycles after the mask was presented.
- R3: Every read output enable is low in any cycle where read-valid is low, whatever the mask value.
- R4: At an edge where clock enable is low, the read mask pipeline does not advance. The mask applied at that edge is discarded, and the read mask in effect stays the same.
- R5: The array write enable of lane i is high in a cycle exactly when write-valid is high, clock enable is high and mask bit i is low. The mask acts in the same cycle, with no register in between.
- R6: Array write data lane i, bits [8i+7:8i], equals input write data lane i when that lane's write enable is high and is zero otherwise.
- R7: Mask bit i controls only byte lane i. The other lanes' read and write controls are unaffected by it.
- R8: When a write burst is cut short, with the mask raised on the remaining beats and a read following, none of the masked beats produce a write enable. The read that follows sees the mask applied two cycles after it was presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable; low freezes the read mask pipeline and blocks writes |
| dqm | input | LANES | Byte mask, one bit per lane, bit i for lane i |
| rd_valid | input | 1 | Read data present on the data path this cycle |
| wr_valid | input | 1 | Write data present on the data path this cycle |
| wr_data | input | LANES*8 | Write data, lane i at bits [8i+7:8i] |
| rd_oe | output | LANES | Per-lane read output enable |
| arr_we | output | LANES | Per-lane array write enable |
| arr_wdata | output | LANES*8 | Write data toward the array, masked lanes zeroed |

## Verification
The write enables and the gated write data are due in the same cycle that the mask and write-valid are presented. The bench drives inputs on the falling edge and checks these outputs a couple of nanoseconds later, before the next rising edge. The read output enable reflects the mask captured at the second-to-last rising edge where clock enable was high. The bench therefore keeps its own two-entry record of masks captured at such edges and compares the read enable against the older entry in each cycle. Drives that cross an edge with clock enable low, and the first cycles after reset, are tagged separately, so each part of the read timing is checked on its own.

// File: rtl/dm_pkg.sv
package dm_pkg;

  // Width of one data byte lane.
  localparam int unsigned LANE_BITS = 8;

  // Read mask latency in cycles, counted from the sampling edge.
  localparam int unsigned READ_MASK_LAT = 2;

  // Replicate one enable bit across a lane of data bits.
  function automatic logic [LANE_BITS-1:0] lane_fill(input logic en);
    return {LANE_BITS{en}};
  endfunction

endpackage

// File: rtl/dm_rd_pipe.sv
module dm_rd_pipe #(
  parameter int unsigned LANES = 2,
  parameter int unsigned DEPTH = dm_pkg::READ_MASK_LAT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [LANES-1:0] mask_in,
  output logic [LANES-1:0] mask_out
);

  logic [LANES-1:0] stage_q [DEPTH];

  // Stage 0 captures the sampled mask; later stages follow the one before.
  // All stages advance together, and only when the internal clock runs.
  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) begin
          stage_q[s] <= '0;
        end else if (adv) begin
          stage_q[s] <= mask_in;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) begin
          stage_q[s] <= '0;
        end else if (adv) begin
          stage_q[s] <= stage_q[s-1];
        end
      end
    end
  end

  assign mask_out = stage_q[DEPTH-1];

endmodule

// File: rtl/dm_wr_gate.sv
module dm_wr_gate #(
  parameter int unsigned LANES = 2
) (
  input  logic                                 run,
  input  logic                                 wr_valid,
  input  logic [LANES-1:0]                     mask,
  input  logic [LANES*dm_pkg::LANE_BITS-1:0]   wdata_in,
  output logic [LANES-1:0]                     we,
  output logic [LANES*dm_pkg::LANE_BITS-1:0]   wdata_out
);

  localparam int unsigned LB = dm_pkg::LANE_BITS;

  // Same-cycle gating: each lane's strobe and data follow its own mask bit.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic lane_en;
    assign lane_en = run & wr_valid & ~mask[i];
    assign we[i]   = lane_en;
    assign wdata_out[i*LB +: LB] = wdata_in[i*LB +: LB] & dm_pkg::lane_fill(lane_en);
  end

endmodule

// File: rtl/dm_rd_gate.sv
module dm_rd_gate #(
  parameter int unsigned LANES = 2
) (
  input  logic             rd_valid,
  input  logic [LANES-1:0] late_mask,
  output logic [LANES-1:0] oe
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign oe[i] = rd_valid & ~late_mask[i];
  end

endmodule

// File: rtl/sdram_dqm_path.sv
module sdram_dqm_path #(
  parameter int unsigned LANES = 2
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                cke,
  input  logic [LANES-1:0]                    dqm,
  input  logic                                rd_valid,
  input  logic                                wr_valid,
  input  logic [LANES*dm_pkg::LANE_BITS-1:0]  wr_data,
  output logic [LANES-1:0]                    rd_oe,
  output logic [LANES-1:0]                    arr_we,
  output logic [LANES*dm_pkg::LANE_BITS-1:0]  arr_wdata
);

  logic [LANES-1:0] late_mask;

  dm_rd_pipe #(
    .LANES(LANES),
    .DEPTH(dm_pkg::READ_MASK_LAT)
  ) u_rd_pipe (
    .clk      (clk),
    .rst      (rst),
    .adv      (cke),
    .mask_in  (dqm),
    .mask_out (late_mask)
  );

  dm_rd_gate #(
    .LANES(LANES)
  ) u_rd_gate (
    .rd_valid  (rd_valid),
    .late_mask (late_mask),
    .oe        (rd_oe)
  );

  dm_wr_gate #(
    .LANES(LANES)
  ) u_wr_gate (
    .run       (cke),
    .wr_valid  (wr_valid),
    .mask      (dqm),
    .wdata_in  (wr_data),
    .we        (arr_we),
    .wdata_out (arr_wdata)
  );

endmodule

// File: rtl/sdram_dqm_path_chk.sv
module sdram_dqm_path_chk #(
  parameter int unsigned LANES = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             cke,
  input logic [LANES-1:0] dqm,
  input logic             rd_valid,
  input logic             wr_valid,
  input logic [LANES-1:0] rd_oe,
  input logic [LANES-1:0] arr_we
);

  logic [1:0] age_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      age_q <= '0;
    end else if (age_q != 2'd3) begin
      age_q <= age_q + 2'd1;
    end
  end

  // R1
  reset_clears_pipe_chk: assert property (@(posedge clk) disable iff (rst)
    (age_q == 2'd0 && rd_valid) |-> (rd_oe == {LANES{1'b1}}));

  // R2
  read_mask_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (age_q >= 2'd2 && $past(cke) && $past(cke, 2) && rd_valid)
      |-> (rd_oe == ~$past(dqm, 2)));

  // R3
  no_oe_without_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> (rd_oe == '0));

  // R4
  frozen_pipe_chk: assert property (@(posedge clk) disable iff (rst)
    (age_q >= 2'd1 && !$past(cke) && $stable(rd_valid)) |-> $stable(rd_oe));

  // R5
  mask_blocks_write_chk: assert property (@(posedge clk) disable iff (rst)
    (arr_we & dqm) == '0);

  // R5
  no_write_when_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!cke || !wr_valid) |-> (arr_we == '0));

endmodule

bind sdram_dqm_path sdram_dqm_path_chk #(.LANES(LANES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cke      (cke),
  .dqm      (dqm),
  .rd_valid (rd_valid),
  .wr_valid (wr_valid),
  .rd_oe    (rd_oe),
  .arr_we   (arr_we)
);

// File: tb/sdram_dqm_path_test.sv
module sdram_dqm_path_test;

  localparam int LANES = 2;
  localparam int LB    = 8;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               cke = 1'b0;
  logic [LANES-1:0]   dqm = '0;
  logic               rd_valid = 1'b0;
  logic               wr_valid = 1'b0;
  logic [LANES*LB-1:0] wr_data = '0;
  logic [LANES-1:0]   rd_oe;
  logic [LANES-1:0]   arr_we;
  logic [LANES*LB-1:0] arr_wdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench record of masks captured at edges where the clock enable was high.
  logic [LANES-1:0] cap_new = '0;
  logic [LANES-1:0] cap_old = '0;
  int since_rst = 0;
  int since_stall = 9;

  always #4 clk = ~clk;

  sdram_dqm_path #(.LANES(LANES)) uut (
    .clk(clk), .rst(rst), .cke(cke), .dqm(dqm),
    .rd_valid(rd_valid), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_oe(rd_oe), .arr_we(arr_we), .arr_wdata(arr_wdata)
  );

  always @(posedge clk) begin
    if (rst) begin
      cap_new     <= '0;
      cap_old     <= '0;
      since_rst   <= 0;
      since_stall <= 9;
    end else begin
      since_rst <= since_rst + 1;
      if (cke) begin
        cap_old     <= cap_new;
        cap_new     <= dqm;
        since_stall <= since_stall + 1;
      end else begin
        since_stall <= 0;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare every output with the bench's expectation for this cycle.
  task automatic check_all();
    for (int i = 0; i < LANES; i++) begin
      logic exp_oe;
      logic exp_we;
      string rtag;
      exp_oe = rd_valid & ~cap_old[i];
      exp_we = wr_valid & cke & ~dqm[i];
      if (!rd_valid)           rtag = "R3 R7 read enable";
      else if (since_rst < 2)  rtag = "R1 R7 read enable";
      else if (since_stall < 2) rtag = "R4 R7 read enable";
      else                     rtag = "R2 R7 read enable";
      check(rtag, {31'd0, rd_oe[i]}, {31'd0, exp_oe});
      check(cke ? "R5 R7 write enable" : "R4 R5 write enable",
            {31'd0, arr_we[i]}, {31'd0, exp_we});
      check("R6 write data lane", {24'd0, arr_wdata[i*LB +: LB]},
            {24'd0, exp_we ? wr_data[i*LB +: LB] : 8'h00});
    end
  endtask

  task automatic drive(input logic c, input logic [LANES-1:0] m,
                       input logic rv, input logic wv, input logic [LANES*LB-1:0] d);
    @(negedge clk);
    cke = c; dqm = m; rd_valid = rv; wr_valid = wv; wr_data = d;
    #2;
    check_all();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    check("R5 reset write enable", {30'd0, arr_we}, 32'd0);
    check("R3 reset read enable", {30'd0, rd_oe}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    cke = 1'b1; rd_valid = 1'b1; dqm = 2'b11;
    #2;
    // R1: pipeline cleared, masks presented now have not reached the output yet
    check("R1 first cycle read enable", {30'd0, rd_oe}, 32'd3);
    drive(1'b1, 2'b11, 1'b1, 1'b0, '0);
    check("R1 second cycle read enable", {30'd0, rd_oe}, 32'd3);
    drive(1'b1, 2'b00, 1'b1, 1'b0, '0);
    check("R2 mask two cycles later", {30'd0, rd_oe}, 32'd0);

    // R8: write burst cut short by masking, then a read
    drive(1'b1, 2'b00, 1'b0, 1'b1, 16'hA1B2);
    check("R8 unmasked beat writes", {30'd0, arr_we}, 32'd3);
    drive(1'b1, 2'b11, 1'b0, 1'b1, 16'hC3D4);
    check("R8 masked beat blocked", {30'd0, arr_we}, 32'd0);
    drive(1'b1, 2'b01, 1'b0, 1'b1, 16'hE5F6);
    check("R8 R7 lane0 masked only", {30'd0, arr_we}, 32'd2);
    drive(1'b1, 2'b00, 1'b1, 1'b0, '0);
    check("R8 read sees earlier mask", {30'd0, rd_oe}, 32'd0);
    drive(1'b1, 2'b00, 1'b1, 1'b0, '0);
    check("R8 read sees lane0 mask", {30'd0, rd_oe}, 32'd2);

    // R4: stall with a mask presented, which must be dropped
    drive(1'b1, 2'b10, 1'b1, 1'b0, '0);
    drive(1'b0, 2'b01, 1'b1, 1'b1, 16'h1234);
    check("R4 frozen write blocked", {30'd0, arr_we}, 32'd0);
    drive(1'b0, 2'b11, 1'b1, 1'b0, '0);
    drive(1'b1, 2'b00, 1'b1, 1'b0, '0);
    check("R4 held mask in effect", {30'd0, rd_oe}, 32'd3);
    drive(1'b1, 2'b00, 1'b1, 1'b0, '0);
    check("R4 stalled masks dropped", {30'd0, rd_oe}, 32'd1);

    // Near-exhaustive sweep of all input combinations in pseudo-random order
    lfsr = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(lfsr[0] | lfsr[7], lfsr[2:1], lfsr[3], lfsr[4], {lfsr[11:4], lfsr[15:8]});
      if (n == 2000) begin
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule